// File: doc/BRIEF.md
# Routed Level Interrupt Aggregator

This block collects 32 level-sensitive interrupt lines and steers each of them onto one of fifteen request outputs, or onto none. Software programs it through a small word-addressed register bus: one register enables individual inputs, one read-only register shows the sampled input levels, and four routing registers hold a 4-bit route code for every input, eight codes per word.

The routing words are packed with the highest-numbered inputs first: the lowest routing word holds inputs 24 to 31 and the highest holds inputs 0 to 7. Inside each word, an input keeps its nibble position from its index modulo eight. An output line stays high for as long as at least one enabled, active input carries that output's code. A parent interrupt controller normally watches the output lines, then reads the status and mask words to find which inputs are pending.

Top module: `irq_route_ctrl`

## Requirements
- R1: After a synchronous reset, the mask word, all four routing words, the read data and every output line are zero.
- R2: A write to byte offset 0x00 stores the mask word, where bit n enables input n. A read returns data on the clock edge that samples the read strobe, so it is valid in the following cycle.
- R3: Byte offset 0x04 reads back the input levels through one register stage. A read in the same cycle as an input change returns the earlier level. Writes to this offset change nothing.
- R4: The routing words sit at byte offsets 0x08, 0x0C, 0x10 and 0x14. Input n takes bits [4*(n%8)+3 : 4*(n%8)] of the word at offset 0x08 + 4*(3 - n/8), and each word reads back as written.
- R5: Route code 0 connects the input to no output. Route code c in 1..15 connects the input to output line c-1.
- R6: An input whose mask bit is 0 drives no output line, whatever its level and route code.
- R7: Output line k is the OR of all inputs that are enabled, active and routed with code k+1, so several inputs may share one line.
- R8: Byte offsets 0x18 and 0x1C read as zero, and writes to them alter no register.
- R9: An input level change shows on the output lines at the second rising edge after it is applied, and not at the first. A mask or routing write shows on the output lines at the rising edge after the one that performs the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 5 | Byte offset of the register accessed |
| wdata | input | 32 | Write data word |
| rdata | output | 32 | Read data, registered |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| irq_out | output | 15 | Registered interrupt request lines |

## Verification
The bench builds the block with its default parameters: 32 inputs, 4-bit route codes and 32-bit words. With these defaults it can sweep every input against all sixteen route codes, so every nibble of every routing word and every output line is exercised, including the inverted word order. The bench reproduces the OR-combination of many inputs with mixed masks and mixed levels by arithmetic on its own copy of the programmed codes. It also covers the whole 3-bit word index space, which contains the two unmapped offsets.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Word indices (byte offset / 4) of the register map.
  localparam int IDX_MASK   = 0;
  localparam int IDX_STAT   = 1;
  localparam int IDX_ROUTE0 = 2;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_IN = 32,
  parameter int DATA_W = 32,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic [NUM_IN-1:0] mask_o,
  output logic [NUM_IN-1:0] stat_o,
  output logic [CODE_W-1:0] code_o [NUM_IN]
);
  localparam int PER_REG = DATA_W / CODE_W;
  localparam int N_ROUTE = NUM_IN / PER_REG;
  localparam int IDX_W   = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [NUM_IN-1:0] mask_q;
  logic [NUM_IN-1:0] stat_q;
  logic [DATA_W-1:0] route_q [N_ROUTE];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rst_d;

  assign idx = addr[ADDR_W-1:2];

  // Input level sampling: one register stage.
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= irq_in;
  end

  // Mask register.
  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (wr_en && idx == IDX_W'(IDX_MASK))
      mask_q <= wdata[NUM_IN-1:0];
  end

  // Routing words, one register per word.
  for (genvar r = 0; r < N_ROUTE; r++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst)
        route_q[r] <= '0;
      else if (wr_en && idx == IDX_W'(IDX_ROUTE0 + r))
        route_q[r] <= wdata;
    end

    a_r4_route_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && idx == IDX_W'(IDX_ROUTE0 + r)) |=> $stable(route_q[r]));
  end

  // Per-input code extraction: highest inputs live in the lowest word.
  for (genvar n = 0; n < NUM_IN; n++) begin : g_code
    assign code_o[n] = route_q[N_ROUTE - 1 - n / PER_REG][CODE_W * (n % PER_REG) +: CODE_W];
  end

  // Read multiplexer; unmapped indices return zero.
  always_comb begin
    rd_mux = '0;
    if (idx == IDX_W'(IDX_MASK))
      rd_mux[NUM_IN-1:0] = mask_q;
    else if (idx == IDX_W'(IDX_STAT))
      rd_mux[NUM_IN-1:0] = stat_q;
    for (int r = 0; r < N_ROUTE; r++) begin
      if (idx == IDX_W'(IDX_ROUTE0 + r))
        rd_mux = route_q[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata  = rdata_q;
  assign mask_o = mask_q;
  assign stat_o = stat_q;

  // R1: register state is clear at the first edge after reset release.
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d && !rst) begin
      a_r1_reset_clear: assert (mask_q == '0 && rdata_q == '0 && route_q[0] == '0);
    end
  end

  a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && idx == IDX_W'(IDX_MASK)) |=> $stable(mask_q));

  a_r3_status_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == IDX_W'(IDX_STAT)) |=> (rdata[NUM_IN-1:0] == $past(stat_q)));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx >= IDX_W'(IDX_ROUTE0 + N_ROUTE)) |=> (rdata == '0));
endmodule

// File: rtl/irq_route_fanin.sv
module irq_route_fanin #(
  parameter int NUM_IN  = 32,
  parameter int CODE_W  = 4,
  parameter int NUM_OUT = (1 << CODE_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IN-1:0]  mask_i,
  input  logic [NUM_IN-1:0]  stat_i,
  input  logic [CODE_W-1:0]  code_i [NUM_IN],
  output logic [NUM_OUT-1:0] irq_out
);
  logic [NUM_OUT-1:0] sel [NUM_IN];
  logic [NUM_OUT-1:0] or_acc;
  logic [NUM_OUT-1:0] irq_out_q;

  // One-hot decode per input; code 0 lands on the dropped bit 0.
  for (genvar n = 0; n < NUM_IN; n++) begin : g_dec
    logic [NUM_OUT:0] full;
    logic             live;
    assign full   = (NUM_OUT + 1)'(1) << code_i[n];
    assign live   = mask_i[n] & stat_i[n];
    assign sel[n] = live ? full[NUM_OUT:1] : '0;
  end

  always_comb begin
    or_acc = '0;
    for (int n = 0; n < NUM_IN; n++) or_acc |= sel[n];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out_q <= '0;
    else     irq_out_q <= or_acc;
  end

  assign irq_out = irq_out_q;

  a_r6_needs_live: assert property (@(posedge clk) disable iff (rst)
    (|irq_out_q) |-> $past(|(mask_i & stat_i)));

  a_r7_out_bound: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ($countones(irq_out_q) <= $past($countones(mask_i & stat_i))));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int NUM_IN = 32,
  parameter int DATA_W = 32,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic [NUM_IN-1:0]        irq_in,
  output logic [(1<<CODE_W)-2:0]   irq_out
);
  localparam int NUM_OUT = (1 << CODE_W) - 1;

  logic [NUM_IN-1:0] mask_w;
  logic [NUM_IN-1:0] stat_w;
  logic [CODE_W-1:0] code_w [NUM_IN];

  irq_route_regs #(
    .NUM_IN(NUM_IN), .DATA_W(DATA_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
    .mask_o(mask_w), .stat_o(stat_w), .code_o(code_w)
  );

  irq_route_fanin #(
    .NUM_IN(NUM_IN), .CODE_W(CODE_W), .NUM_OUT(NUM_OUT)
  ) u_fanin (
    .clk(clk), .rst(rst), .mask_i(mask_w), .stat_i(stat_w),
    .code_i(code_w), .irq_out(irq_out)
  );
endmodule

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] irq_in = '0;
  logic [14:0] irq_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [3:0] code_m [32];

  always #5 clk = ~clk;

  irq_route_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [4:0] route_addr(input int n);
    return 5'(8 + 4 * (3 - n / 8));
  endfunction

  function automatic logic [31:0] model_out(input logic [31:0] m, input logic [31:0] lv);
    logic [31:0] o = '0;
    for (int i = 0; i < 32; i++)
      if (m[i] && lv[i] && code_m[i] != 0) o[code_m[i] - 1] = 1'b1;
    return o;
  endfunction

  task automatic load_codes();
    logic [31:0] w [4];
    for (int r = 0; r < 4; r++) w[r] = '0;
    for (int i = 0; i < 32; i++) w[3 - i / 8][4 * (i % 8) +: 4] = code_m[i];
    for (int r = 0; r < 4; r++) wr(5'(8 + 4 * r), w[r]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pats [5];
    irq_in = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 irq_out", 32'(irq_out), '0);
    check("R1 rdata", rdata, '0);
    rd(5'h00, d); check("R1 mask", d, '0);
    for (int r = 0; r < 4; r++) begin
      rd(5'(8 + 4 * r), d); check("R1 route", d, '0);
    end
    check("R1 no output with mask clear", 32'(irq_out), '0);

    // R2: mask write and read-back
    wr(5'h00, 32'hDEADBEEF);
    rd(5'h00, d); check("R2 mask readback", d, 32'hDEADBEEF);
    wr(5'h00, 32'h0);
    rd(5'h00, d); check("R2 mask cleared", d, 32'h0);

    // R3: status path and write-protection
    @(negedge clk); irq_in = 32'h12345678;
    @(negedge clk);
    rd(5'h04, d); check("R3 status level", d, 32'h12345678);
    wr(5'h04, 32'hFFFFFFFF);
    rd(5'h04, d); check("R3 status write ignored", d, 32'h12345678);
    @(negedge clk);
    irq_in = 32'hA5A5A5A5; rd_en = 1'b1; addr = 5'h04;
    @(negedge clk);
    rd_en = 1'b0;
    check("R3 same-cycle read returns old level", rdata, 32'h12345678);
    rd(5'h04, d); check("R3 status new level", d, 32'hA5A5A5A5);

    // R8: unmapped offsets
    wr(5'h08, 32'h13579BDF);
    wr(5'h00, 32'h0F0F0F0F);
    wr(5'h18, 32'hFFFFFFFF);
    wr(5'h1C, 32'hFFFFFFFF);
    rd(5'h18, d); check("R8 unmapped 0x18", d, '0);
    rd(5'h1C, d); check("R8 unmapped 0x1C", d, '0);
    rd(5'h00, d); check("R8 mask untouched", d, 32'h0F0F0F0F);
    rd(5'h08, d); check("R8 route0 untouched", d, 32'h13579BDF);
    for (int r = 1; r < 4; r++) begin
      rd(5'(8 + 4 * r), d); check("R8 route untouched", d, '0);
    end
    wr(5'h08, 32'h0);

    // R4/R5: every input against every code
    irq_in = '1;
    wr(5'h00, 32'hFFFFFFFF);
    for (int n = 0; n < 32; n++) begin
      for (int c = 0; c < 16; c++) begin
        logic [31:0] word = 32'(c) << (4 * (n % 8));
        logic [31:0] exp  = (c == 0) ? 32'h0 : (32'h1 << (c - 1));
        wr(route_addr(n), word);
        @(negedge clk);
        check("R5 route code to output", 32'(irq_out), exp);
        if (c == 9) begin
          rd(route_addr(n), d); check("R4 route word layout", d, word);
        end
      end
      wr(route_addr(n), 32'h0);
    end

    // R6/R7: many inputs, mixed masks
    for (int i = 0; i < 32; i++) code_m[i] = 4'((i % 15) + 1);
    code_m[5] = 4'd0;
    load_codes();
    pats[0] = 32'h00000000; pats[1] = 32'hFFFFFFFF; pats[2] = 32'hAAAAAAAA;
    pats[3] = 32'h80000001; pats[4] = 32'h0000FFFF;
    for (int p = 0; p < 5; p++) begin
      wr(5'h00, pats[p]);
      @(negedge clk);
      check("R6 mask gating", 32'(irq_out), model_out(pats[p], irq_in));
    end
    wr(5'h00, 32'hFFFFFFFF);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); irq_in = ~pats[p] ^ 32'h00FF00FF;
      @(negedge clk); @(negedge clk);
      check("R7 OR combination", 32'(irq_out), model_out(32'hFFFFFFFF, irq_in));
    end
    for (int b = 0; b < 32; b++) begin
      wr(5'h00, 32'h1 << b);
      @(negedge clk);
      check("R6 single enable", 32'(irq_out), model_out(32'h1 << b, irq_in));
    end

    // R9: latency of inputs and configuration writes
    wr(5'h00, 32'hFFFFFFFF);
    @(negedge clk); irq_in = 32'hFFFFFFFF;
    @(negedge clk); @(negedge clk);
    check("R9 settled", 32'(irq_out), model_out(32'hFFFFFFFF, 32'hFFFFFFFF));
    irq_in = 32'h0;
    @(negedge clk);
    check("R9 input not yet at first edge", 32'(irq_out), model_out(32'hFFFFFFFF, 32'hFFFFFFFF));
    @(negedge clk);
    check("R9 input at second edge", 32'(irq_out), 32'h0);
    irq_in = 32'hFFFFFFFF;
    @(negedge clk); @(negedge clk);
    wr(5'h00, 32'h0);
    check("R9 mask write not yet visible", 32'(irq_out), model_out(32'hFFFFFFFF, 32'hFFFFFFFF));
    @(negedge clk);
    check("R9 mask write visible next edge", 32'(irq_out), 32'h0);
    wr(5'h00, 32'h00000001);
    wr(route_addr(0), 32'h0000000F);
    check("R9 route write not yet visible", 32'(irq_out), 32'h1);
    @(negedge clk);
    check("R9 route write visible next edge", 32'(irq_out), 32'h4000);

    finish_run();
  end
endmodule